// File: doc/BRIEF.md
# Line-Reversal Keypad Decoder

This block finds which key of a 4x4 matrix keypad is pressed. It does not walk a one-hot strobe across the columns. It reverses the direction of the lines instead.

First the row lines are left floating, so external pull-ups hold them high, and every column line is pulled low. The rows are then read back. A low row bit shows which row holds the key. Next the roles swap: the rows are pulled low, the columns float, and the columns are read back.

The two 4-bit samples form an 8-bit row/column code, with the rows in the upper nibble. A code that has exactly one low bit in each nibble becomes a key number from 0 to 15. That number is latched together with a seven-segment pattern and an LED copy, and a one-cycle strobe marks each new key. Before the block accepts another press, the key must be let go and the rows must read all-high for a full settle period.

Each line has its own output-enable and drive-value pin, so a board-level tristate buffer can be built from them. Whenever a line is enabled, its drive value is low.

Top module: `kpad_reverse_decoder`

## Requirements
- R1: A synchronous active-high reset clears `key_code`, `seg_out`, `led_out` and `key_valid` to zero. It puts the block in the row phase, with `row_oe` = 0 and `col_oe` all ones.
- R2: In the row phase every enabled line is driven low (`row_drv` = `col_drv` = 0), all columns are enabled and all rows are released.
  - If all four rows read high when sampled, the block stays in the row phase and `key_valid` stays low.
- R3: A row sample with any low bit starts the column phase, in which `row_oe` is all ones and `col_oe` is zero. The column phase lasts exactly SETTLE cycles.
- R4: Each phase waits SETTLE cycles after its lines change direction before it samples. For a key held from the row phase onward, `key_valid` rises between SETTLE+1 and 2*SETTLE clock edges after the press.
- R5: The key number is row index * 4 + column index. The index is the position of the low bit in its nibble, and bit 0 is index 0.
- R6: On a valid decode, `key_valid` is high for exactly one cycle. In that cycle `key_code`, `seg_out` and `led_out` take the new key (with `led_out` equal to `key_code`), and they hold that value until the next valid decode.
- R7: `seg_out` is active high with bit 6 = segment a down to bit 0 = segment g. The patterns for keys 0 to F are:
  - 0: 1111110, 1: 0110000, 2: 1101101, 3: 1111001
  - 4: 0110011, 5: 1011011, 6: 1011111, 7: 1110000
  - 8: 1111111, 9: 1111011, A: 1110111, b: 0011111
  - C: 1001110, d: 0111101, E: 1001111, F: 1000111
- R8: A code with more than one low bit in either nibble is discarded: no strobe is given, the outputs do not change, and the block returns to the row phase. This covers two keys in one row, two keys in one column, and two keys in different rows and columns.
- R9: A key released during the column phase gives an all-high column nibble. That code is discarded with no strobe and no output change.
- R10: After a valid decode the block re-enters the row-line configuration and accepts no new key until the rows have read all-high for SETTLE consecutive cycles. A shorter release, or a key held down, produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_in | input | 4 | Row line levels read back (pulled up externally) |
| col_in | input | 4 | Column line levels read back (pulled up externally) |
| row_oe | output | 4 | Output enable per row line |
| row_drv | output | 4 | Value driven on enabled row lines (always low) |
| col_oe | output | 4 | Output enable per column line |
| col_drv | output | 4 | Value driven on enabled column lines (always low) |
| key_code | output | 4 | Latched key number 0..15 |
| key_valid | output | 1 | One-cycle strobe for a new key |
| seg_out | output | 7 | Latched seven-segment pattern, abcdefg, active high |
| led_out | output | 4 | Latched LED copy of the key number |

## Verification
The bench models the keypad as wired-AND lines with pull-ups and sets the block's settle delay to 4 cycles.

A key pressed during the row phase makes `key_valid` rise after no fewer than SETTLE+1 and no more than 2*SETTLE edges, depending on where the row-phase counter stood. The bench counts edges from the press, checks that the count falls in that window, and reads the latched outputs on the same falling edge as the strobe. It reads them again on the next falling edge, where the strobe must already be low.

For the cases with no output, the bench watches a window of at least 4*SETTLE cycles. That window is longer than any path to a strobe, so a missing `key_valid` and unchanged outputs at the end of it show the press was discarded.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  typedef enum logic [1:0] {
    PH_ROW = 2'd0,
    PH_COL = 2'd1,
    PH_REL = 2'd2
  } kpd_phase_e;

  // Active-high segments, bit 6 = a ... bit 0 = g
  function automatic logic [6:0] seg7_of(input logic [3:0] v);
    logic [6:0] s;
    case (v)
      4'h0: s = 7'b1111110;
      4'h1: s = 7'b0110000;
      4'h2: s = 7'b1101101;
      4'h3: s = 7'b1111001;
      4'h4: s = 7'b0110011;
      4'h5: s = 7'b1011011;
      4'h6: s = 7'b1011111;
      4'h7: s = 7'b1110000;
      4'h8: s = 7'b1111111;
      4'h9: s = 7'b1111011;
      4'hA: s = 7'b1110111;
      4'hB: s = 7'b0011111;
      4'hC: s = 7'b1001110;
      4'hD: s = 7'b0111101;
      4'hE: s = 7'b1001111;
      default: s = 7'b1000111;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/kpd_settle_timer.sv
module kpd_settle_timer #(
  parameter int SETTLE = 16,
  localparam int CW = (SETTLE < 2) ? 1 : $clog2(SETTLE)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);

  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(SETTLE - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/kpd_code_decode.sv
module kpd_code_decode #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int KW = $clog2(ROWS * COLS)
) (
  input  logic [ROWS-1:0] row_s,
  input  logic [COLS-1:0] col_s,
  output logic            ok,
  output logic [KW-1:0]   key
);

  int ri, ci;

  always_comb begin
    ri = 0;
    ci = 0;
    for (int i = 0; i < ROWS; i++) if (!row_s[i]) ri = i;
    for (int j = 0; j < COLS; j++) if (!col_s[j]) ci = j;
    ok  = ($countones(~row_s) == 1) && ($countones(~col_s) == 1);
    key = KW'(ri * COLS + ci);
  end

endmodule

// File: rtl/kpd_seg_enc.sv
module kpd_seg_enc #(
  parameter int KW = 4
) (
  input  logic [KW-1:0] key,
  output logic [6:0]    seg
);
  import kpd_pkg::*;

  always_comb seg = seg7_of(4'(key));

endmodule

// File: rtl/kpad_reverse_decoder.sv
module kpad_reverse_decoder #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int SETTLE = 16,
  localparam int KW = $clog2(ROWS * COLS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ROWS-1:0] row_in,
  input  logic [COLS-1:0] col_in,
  output logic [ROWS-1:0] row_oe,
  output logic [ROWS-1:0] row_drv,
  output logic [COLS-1:0] col_oe,
  output logic [COLS-1:0] col_drv,
  output logic [KW-1:0]   key_code,
  output logic            key_valid,
  output logic [6:0]      seg_out,
  output logic [KW-1:0]   led_out
);
  import kpd_pkg::*;

  kpd_phase_e      phase;
  logic [ROWS-1:0] row_s;
  logic            t_done, t_clr;
  logic            rows_idle;
  logic            dec_ok;
  logic [KW-1:0]   dec_key;
  logic [6:0]      dec_seg;

  assign rows_idle = (row_in == '1);
  assign t_clr     = t_done || ((phase == PH_REL) && !rows_idle);

  assign row_oe  = (phase == PH_COL) ? '1 : '0;
  assign col_oe  = (phase == PH_COL) ? '0 : '1;
  assign row_drv = '0;
  assign col_drv = '0;

  kpd_settle_timer #(.SETTLE(SETTLE)) tmr_i (
    .clk (clk),
    .rst (rst),
    .clr (t_clr),
    .done(t_done)
  );

  kpd_code_decode #(.ROWS(ROWS), .COLS(COLS)) dec_i (
    .row_s(row_s),
    .col_s(col_in),
    .ok   (dec_ok),
    .key  (dec_key)
  );

  kpd_seg_enc #(.KW(KW)) seg_i (
    .key(dec_key),
    .seg(dec_seg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_ROW;
      row_s     <= '1;
      key_code  <= '0;
      seg_out   <= '0;
      led_out   <= '0;
      key_valid <= 1'b0;
    end else begin
      key_valid <= 1'b0;
      case (phase)
        PH_ROW: begin
          if (t_done && !rows_idle) begin
            row_s <= row_in;
            phase <= PH_COL;
          end
        end
        PH_COL: begin
          if (t_done) begin
            if (dec_ok) begin
              key_code  <= dec_key;
              led_out   <= dec_key;
              seg_out   <= dec_seg;
              key_valid <= 1'b1;
              phase     <= PH_REL;
            end else begin
              phase <= PH_ROW;
            end
          end
        end
        PH_REL: begin
          if (t_done && rows_idle) phase <= PH_ROW;
        end
        default: phase <= PH_ROW;
      endcase
    end
  end

endmodule

// File: rtl/kpad_reverse_decoder_chk.sv
module kpad_reverse_decoder_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int KW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [ROWS-1:0] row_oe,
  input logic [COLS-1:0] col_oe,
  input logic [KW-1:0]   key_code,
  input logic            key_valid,
  input logic [6:0]      seg_out,
  input logic [KW-1:0]   led_out
);

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> ($stable(key_code) && $stable(seg_out) && $stable(led_out)));

  p_led_copy_r6: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (led_out == key_code));

  p_dir_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    (row_oe != '0) |-> (col_oe == '0 && row_oe == '1));

  p_valid_after_col_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(key_valid) |-> ($past(row_oe) == '1 && $past(col_oe) == '0));

  p_release_cfg_r10: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (col_oe == '1 && row_oe == '0));

endmodule

bind kpad_reverse_decoder kpad_reverse_decoder_chk #(
  .ROWS(ROWS), .COLS(COLS), .KW(KW)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .row_oe   (row_oe),
  .col_oe   (col_oe),
  .key_code (key_code),
  .key_valid(key_valid),
  .seg_out  (seg_out),
  .led_out  (led_out)
);

// File: tb/kpad_reverse_decoder_tb_top.sv
module kpad_reverse_decoder_tb_top;

  localparam int S = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_in, col_in, row_oe, row_drv, col_oe, col_drv;
  logic [3:0] key_code, led_out;
  logic       key_valid;
  logic [6:0] seg_out;
  logic [15:0] mask = '0;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  kpad_reverse_decoder #(.ROWS(4), .COLS(4), .SETTLE(S)) dut_i (
    .clk(clk), .rst(rst), .row_in(row_in), .col_in(col_in),
    .row_oe(row_oe), .row_drv(row_drv), .col_oe(col_oe), .col_drv(col_drv),
    .key_code(key_code), .key_valid(key_valid), .seg_out(seg_out),
    .led_out(led_out)
  );

  // keypad: pull-ups, closed switches join a row and a column
  always_comb begin
    for (int r = 0; r < 4; r++) row_in[r] = !(row_oe[r] && !row_drv[r]);
    for (int c = 0; c < 4; c++) col_in[c] = !(col_oe[c] && !col_drv[c]);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (mask[r*4+c]) begin
          if (col_oe[c] && !col_drv[c]) row_in[r] = 1'b0;
          if (row_oe[r] && !row_drv[r]) col_in[c] = 1'b0;
        end
  end

  function automatic logic [6:0] exp_seg(input int v);
    case (v)
      0: return 7'b1111110;  1: return 7'b0110000;
      2: return 7'b1101101;  3: return 7'b1111001;
      4: return 7'b0110011;  5: return 7'b1011011;
      6: return 7'b1011111;  7: return 7'b1110000;
      8: return 7'b1111111;  9: return 7'b1111011;
      10: return 7'b1110111; 11: return 7'b0011111;
      12: return 7'b1001110; 13: return 7'b0111101;
      14: return 7'b1001111; default: return 7'b1000111;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watch n cycles, return number of strobes seen
  task automatic watch(input int n, output int strobes);
    strobes = 0;
    repeat (n) begin
      @(negedge clk);
      if (key_valid) strobes++;
    end
  endtask

  task automatic press_decode(input int idx);
    int lat, colcyc, r, c;
    bit seen;
    lat = 0; colcyc = 0; seen = 0;
    r = idx / 4; c = idx % 4;
    mask = 16'(1) << idx;
    while (!seen && lat < 6*S) begin
      @(negedge clk);
      lat++;
      if (row_oe == 4'hF) colcyc++;
      if (key_valid) seen = 1;
    end
    check(seen, "R4 strobe seen", int'(seen), 1);
    check(lat >= S+1 && lat <= 2*S, "R4 latency", lat, 2*S);
    check(colcyc == S, "R3 column phase length", colcyc, S);
    check(int'(key_code) == r*4+c, "R5 key number", int'(key_code), r*4+c);
    check(seg_out == exp_seg(idx), "R7 segments", int'(seg_out), int'(exp_seg(idx)));
    check(led_out == key_code, "R6 led copy", int'(led_out), int'(key_code));
    @(negedge clk);
    check(!key_valid, "R6 one-cycle strobe", int'(key_valid), 0);
    check(int'(key_code) == idx, "R6 held", int'(key_code), idx);
  endtask

  task automatic release_wait(input int extra);
    mask = '0;
    step(S + 2 + extra);
  endtask

  initial begin
    int st;
    logic [3:0] prev;
    step(3);
    check(key_code == 0 && led_out == 0 && seg_out == 0 && !key_valid,
          "R1 reset outputs", int'(seg_out), 0);
    check(row_oe == 4'h0 && col_oe == 4'hF, "R1 reset phase", int'(col_oe), 15);
    rst = 1'b0;

    // idle: no key, row phase holds
    st = 0;
    for (int i = 0; i < 5*S; i++) begin
      @(negedge clk);
      if (key_valid) st++;
      if (row_oe != 4'h0 || col_oe != 4'hF || row_drv != 0 || col_drv != 0) st += 100;
    end
    check(st == 0, "R2 idle row phase", st, 0);

    // full sweep, varied pre-delay
    for (int k = 0; k < 16; k++) begin
      step(k % S);
      press_decode(k);
      release_wait(k % 3);
    end

    // multiple keys: different rows and columns, same row, same column
    for (int t = 0; t < 3; t++) begin
      prev = key_code;
      mask = (t == 0) ? 16'h0021 : (t == 1) ? 16'h0050 : 16'h0202;
      watch(6*S, st);
      check(st == 0, "R8 multi-key no strobe", st, 0);
      check(key_code == prev, "R8 multi-key output kept", int'(key_code), int'(prev));
      release_wait(0);
    end

    // release during column phase
    prev = key_code;
    mask = 16'(1) << 6;
    st = 0;
    while (row_oe != 4'hF && st < 6*S) begin @(negedge clk); st++; end
    mask = '0;
    watch(4*S, st);
    check(st == 0, "R9 release between phases", st, 0);
    check(key_code == prev, "R9 output kept", int'(key_code), int'(prev));

    // release gate
    press_decode(9);
    watch(4*S, st);
    check(st == 0, "R10 held key no repeat", st, 0);
    mask = '0;
    step(S - 2);
    mask = 16'(1) << 3;
    watch(4*S, st);
    check(st == 0, "R10 short release ignored", st, 0);
    check(key_code == 9, "R10 output kept", int'(key_code), 9);
    release_wait(0);
    press_decode(3);
    release_wait(0);

    // reset mid-run
    rst = 1'b1;
    step(2);
    check(key_code == 0 && led_out == 0 && seg_out == 0 && col_oe == 4'hF,
          "R1 reset after use", int'(key_code), 0);
    rst = 1'b0;
    step(2);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule